// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell Bank

This block is a bank of pad cells for a programmable-logic fabric. Each cell sits between one chip pin and the internal routing. Its own configuration bits set it up as a pure receiver, a pure driver, or a bidirectional pin whose three-state driver is switched by a chosen enable. A separate per-cell bit picks the drive style. In push-pull style the cell drives the pin both high and low. In open-drain style it only pulls the pin low, so an external pull-up can build wired-AND buses or arbitration lines.

The enable for a bidirectional cell comes from one of four sources: a constant "on", either of two chip-wide output-enable lines, or a per-cell enable computed by the logic array. Whatever level is on the pin goes back to the routing in the same cycle. This is true even while the cell drives it, so logic can read back what it drives, or see another driver pulling an open-drain line low. A registered copy of that feedback is also provided. The chip reset clears it.

Top module: `iocell_bank`

## Requirements
- R1: With mode field `cfg_mode[2i+1:2i]` = 2'b00 (input only), the cell never drives its pin, whatever the enable sources and data are.
- R2: With mode 2'b01 (output only), the driver is enabled at all times, regardless of the enable select, and `core_in[i]` reads 0.
- R3: With mode 2'b10 or 2'b11 (bidirectional), the driver is enabled exactly when the selected enable source is 1.
- R4: The enable select `cfg_oesel[2i+1:2i]` encodes 2'b00 = always enabled, 2'b01 = `goe[0]`, 2'b10 = `goe[1]`, 2'b11 = `pt_oe[i]`.
- R5: With `cfg_drive[i]` = 1 (erased, push-pull), an enabled cell drives `core_out[i]` onto the pin, both 1 and 0.
- R6: With `cfg_drive[i]` = 0 (programmed, open-drain), an enabled cell drives 0 when `core_out[i]` is 0 and leaves the pin floating when it is 1. With a pull-up, the pin reads 1 whenever the data is 1 or the driver is disabled and nothing else drives it.
- R7: In input-only and bidirectional modes, `core_in[i]` follows the pin level combinationally, including a level the cell drives itself.
- R8: `core_in_q[i]` captures `core_in[i]` on every rising clock edge. An active-low asynchronous `rst_n` clears it to 0 at once.
- R9: Each cell's behaviour depends only on its own configuration, data and enable bits and the shared `goe` lines. Cells with different settings do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the feedback capture register |
| rst_n | input | 1 | Asynchronous active-low reset of the capture register |
| core_out | input | NPIN | Data from the logic array, one bit per cell |
| pt_oe | input | NPIN | Per-cell enable computed by the logic array |
| goe | input | 2 | Chip-wide output-enable lines |
| cfg_mode | input | 2*NPIN | Per-cell direction mode, two bits each |
| cfg_oesel | input | 2*NPIN | Per-cell enable-source select, two bits each |
| cfg_drive | input | NPIN | Per-cell drive style: 1 push-pull, 0 open-drain |
| pad | inout | NPIN | Chip pins |
| core_in | output | NPIN | Pin level fed back to the routing |
| core_in_q | output | NPIN | Registered copy of core_in |

## Verification
The bench builds the bank with NPIN = 4 and puts a pull-up and an external three-state driver on every pin. With four cells, every combination of mode, drive style, enable select, both global enables, data, per-cell enable and external pin stimulus can be swept, and cell-dependent data inversions exercise several cells at once. A second phase gives each of the four cells a different, computed setting in every step to show the cells are independent. It ends with an asynchronous reset between clock edges.

// File: rtl/iocell_bank.sv
module iocell_bank #(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   core_out,
  input  logic [NPIN-1:0]   pt_oe,
  input  logic [1:0]        goe,
  input  logic [2*NPIN-1:0] cfg_mode,
  input  logic [2*NPIN-1:0] cfg_oesel,
  input  logic [NPIN-1:0]   cfg_drive,
  inout  wire  [NPIN-1:0]   pad,
  output logic [NPIN-1:0]   core_in,
  output logic [NPIN-1:0]   core_in_q
);

  localparam int FW = 2;
  localparam logic [FW-1:0] M_IN  = 2'b00;
  localparam logic [FW-1:0] M_OUT = 2'b01;

  for (genvar g = 0; g < NPIN; g++) begin : g_cell
    logic [FW-1:0] mode;
    logic [FW-1:0] sel;
    logic          oe_src;
    logic          drv_en;
    logic          drv_on;

    assign mode = cfg_mode[FW*g +: FW];
    assign sel  = cfg_oesel[FW*g +: FW];

    always_comb begin
      case (sel)
        2'b00:   oe_src = 1'b1;
        2'b01:   oe_src = goe[0];
        2'b10:   oe_src = goe[1];
        default: oe_src = pt_oe[g];
      endcase
    end

    assign drv_en = (mode == M_OUT) | (mode[1] & oe_src);
    assign drv_on = drv_en & (cfg_drive[g] | ~core_out[g]);

    assign pad[g]     = drv_on ? core_out[g] : 1'bz;
    assign core_in[g] = (mode == M_OUT) ? 1'b0 : pad[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) core_in_q[g] <= 1'b0;
      else        core_in_q[g] <= core_in[g];
    end

    a_r5_pushpull_level: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_drive[g] && drv_en) |-> (pad[g] == core_out[g]));

    a_r6_opendrain_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_drive[g] && drv_en && !core_out[g]) |-> (pad[g] == 1'b0));

    a_r2_output_forced_on: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == M_OUT) && cfg_drive[g]) |-> (pad[g] == core_out[g]));

    a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && cfg_drive[g] && drv_en) |-> (core_in[g] == core_out[g]));

    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (core_in_q[g] == $past(core_in[g])));

    a_r1_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_IN) |-> !drv_on);
  end

endmodule

// File: tb/iocell_bank_tb_top.sv
module iocell_bank_tb_top;
  localparam int NP = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [NP-1:0]   core_out, pt_oe, cfg_drive, ext_en, ext_val;
  logic [1:0]      goe;
  logic [2*NP-1:0] cfg_mode, cfg_oesel;
  wire  [NP-1:0]   pad;
  logic [NP-1:0]   core_in, core_in_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  for (genvar i = 0; i < NP; i++) begin : g_pin
    pullup (pad[i]);
    assign pad[i] = ext_en[i] ? ext_val[i] : 1'bz;
  end

  iocell_bank #(.NPIN(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_out(core_out), .pt_oe(pt_oe), .goe(goe),
    .cfg_mode(cfg_mode), .cfg_oesel(cfg_oesel), .cfg_drive(cfg_drive),
    .pad(pad), .core_in(core_in), .core_in_q(core_in_q)
  );

  function automatic logic will_drive(int i);
    logic [1:0] m, s;
    logic en, src;
    m = cfg_mode[2*i +: 2];
    s = cfg_oesel[2*i +: 2];
    case (s)
      2'd0: src = 1'b1;
      2'd1: src = goe[0];
      2'd2: src = goe[1];
      default: src = pt_oe[i];
    endcase
    en = (m == 2'd1) || (m >= 2'd2 && src);
    return en && (cfg_drive[i] || !core_out[i]);
  endfunction

  task automatic chk(string req, int i, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cell %0d actual %b expected %b", req, i, act, exp);
    end
  endtask

  // ext_mode: 0 none, 1 external 0, 2 external 1 (only where the cell floats)
  task automatic apply(int ext_mode, string req);
    logic [NP-1:0] pexp, iexp;
    for (int i = 0; i < NP; i++) begin
      ext_en[i]  = (ext_mode != 0) && !will_drive(i);
      ext_val[i] = (ext_mode == 2);
    end
    #2;
    for (int i = 0; i < NP; i++) begin
      pexp[i] = will_drive(i) ? core_out[i] : (ext_en[i] ? ext_val[i] : 1'b1);
      iexp[i] = (cfg_mode[2*i +: 2] == 2'd1) ? 1'b0 : pexp[i];
      chk(req, i, pad[i], pexp[i]);
      chk("R7", i, core_in[i], iexp[i]);
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < NP; i++) chk("R8", i, core_in_q[i], iexp[i]);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; core_out = '0; pt_oe = '0; goe = '0; cfg_drive = '1;
    cfg_mode = '0; cfg_oesel = '0; ext_en = '0; ext_val = '0;
    core_out = '1;
    cfg_oesel = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      chk("R8", i, core_in_q[i], 1'b0);
      chk("R1", i, pad[i], 1'b1);
    end
    ext_en = '1; ext_val = '0;
    #1;
    for (int i = 0; i < NP; i++) chk("R1", i, core_in[i], 1'b0);
    ext_en = '0;
    rst_n = 1'b1;
    @(negedge clk);

    // Phase 1: uniform configuration, full sweep (R1-related checks per field)
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 4; s++)
          for (int gv = 0; gv < 4; gv++)
            for (int p = 0; p < 2; p++)
              for (int o = 0; o < 2; o++)
                for (int e = 0; e < 3; e++) begin
                  for (int i = 0; i < NP; i++) begin
                    cfg_mode[2*i +: 2]  = 2'(m);
                    cfg_oesel[2*i +: 2] = 2'(s);
                    cfg_drive[i] = d[0];
                    core_out[i]  = o[0] ^ i[0];
                    pt_oe[i]     = p[0] ^ i[1];
                  end
                  goe = 2'(gv);
                  if (m == 0) apply(e, "R1");
                  else if (m == 1) apply(e, "R2");
                  else if (d == 0) apply(e, "R6");
                  else if (s != 0) apply(e, "R4");
                  else apply(e, "R3");
                end

    // R5: push-pull drives high against an external pull-down attempt is avoided; check explicit high
    cfg_mode = '0; cfg_drive = '1; cfg_oesel = '0;
    for (int i = 0; i < NP; i++) cfg_mode[2*i +: 2] = 2'd2;
    core_out = 4'b1010; goe = 2'b00;
    apply(0, "R5");

    // Phase 2: each cell with its own computed setting (R9)
    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < NP; i++) begin
        int h;
        h = (k * 37 + i * 11 + k * i * 5 + (k >> 3)) & 255;
        cfg_mode[2*i +: 2]  = 2'(h);
        cfg_oesel[2*i +: 2] = 2'(h >> 2);
        cfg_drive[i] = h[4];
        core_out[i]  = h[5];
        pt_oe[i]     = h[6];
      end
      goe = 2'(k >> 1);
      apply(k % 3, "R9");
    end

    // R8: asynchronous reset between clock edges
    cfg_mode = '0; ext_en = '1; ext_val = '1;
    @(posedge clk); #1;
    for (int i = 0; i < NP; i++) chk("R8", i, core_in_q[i], 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < NP; i++) chk("R8", i, core_in_q[i], 1'b0);
    ext_en = '0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule